// File: doc/BRIEF.md
# Jump Trace Recorder

This block keeps a short history of program-flow breaks for a debugger. Each time the retire stage reports a taken jump, the block stores two addresses together as one entry: the address the jump was fetched from and the address execution continued at. Sequential execution and squashed instructions never raise the strobe, so they leave nothing behind.

Software reaches the block through a small register port with three locations. A control word switches the storage on and starts or stops recording. A status word gives the number of stored entries and a sticky overflow flag. A data location hands back stored addresses one word per read, starting with the newest entry. Each entry is read as its target word followed by its source word, and the entry count drops only after the source word has been read. The usual sequence is to write 0x3 to start recording, write 0x1 to freeze the history while keeping it, drain the entries, and then write 0x0 to power the block down.

Top module: `jump_trace_buf`

## Requirements
- R1: After reset, control (address 0) and status (address 1) read 0, and a read of the data location (address 2) returns 0.
- R2: While control bit 0 (power) and control bit 1 (record) are both 1, each cycle with `disc_valid` high stores one entry (`disc_src`, `disc_dst`). The status bits [4:0] then hold the number of stored entries.
- R3: While either control bit is 0, `disc_valid` stores nothing and the status count does not change.
- R4: With power 1 and record 0, data reads return the newest entry first. Within each entry the target address comes before the source address.
- R5: Reading the target word of an entry leaves the status count unchanged. Reading the source word that follows lowers the count by one.
- R6: A data read returns 0 and changes no state when the count is 0, when record is 1, or when power is 0.
- R7: When an entry arrives while DEPTH (16) entries are already stored, the oldest entry is dropped, the count stays at DEPTH, and status bit 8 (overflow) is set and stays set.
- R8: Writing control with bit 0 = 0 clears the count and the overflow flag. Writing 0x1 stops recording and keeps every stored entry.
- R9: A control write that changes the record bit from 0 to 1 resets the word selector, so the next drain starts on a target word even if a previous drain stopped halfway through an entry.
- R10: Control reads back only bits [1:0], with all higher bits 0. Writes to the status or data locations have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disc_valid | input | 1 | Taken-jump strobe from the retire stage |
| disc_src | input | 32 | Address of the jump instruction |
| disc_dst | input | 32 | Address the jump lands on |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe; a data read pops one word |
| reg_rdata | output | 32 | Read data, valid in the same cycle as `reg_rd` |

## Verification
The bench starts with a directed sequence of three jumps and drains it one word at a time, checking status after every word. A design that lowered the count on the target word, or returned source before target, fails this sequence. Random runs then store more than 16 entries, to catch a design that overwrites the newest entry instead of the oldest, stops counting incorrectly, or loses the overflow flag. Further directed cases read an empty buffer, read while recording is on, and send strobes with only one control bit set. A design that popped on those reads, or captured with a single bit set, would show a drifting count. A final case stops a drain halfway through an entry and then re-enables recording, to catch a word selector that does not return to the target word.

// File: rtl/jump_trace_buf.sv
module jump_trace_buf #(
  parameter int DEPTH = 16,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          disc_valid,
  input  logic [AW-1:0] disc_src,
  input  logic [AW-1:0] disc_dst,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_wdata,
  input  logic          reg_rd,
  output logic [AW-1:0] reg_rdata
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  logic          pwr_q, en_q, half_q, ovf_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] wp_q;
  logic [AW-1:0] src_m [DEPTH];
  logic [AW-1:0] dst_m [DEPTH];

  wire rec     = pwr_q & en_q;
  wire cap     = rec & disc_valid;
  wire ctrl_wr = reg_wr && (reg_addr == A_CTRL);
  wire data_rd = reg_rd && (reg_addr == A_DATA);
  wire pop     = data_rd && pwr_q && !en_q && (cnt_q != '0);
  wire full    = (cnt_q == CW'(DEPTH));

  wire [PW-1:0] top_idx = (wp_q == '0) ? PW'(DEPTH - 1) : wp_q - 1'b1;
  wire [PW-1:0] wp_inc  = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;

  always_ff @(posedge clk) begin
    if (cap) begin
      src_m[wp_q] <= disc_src;
      dst_m[wp_q] <= disc_dst;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_q  <= 1'b0;
      en_q   <= 1'b0;
      half_q <= 1'b0;
      ovf_q  <= 1'b0;
      cnt_q  <= '0;
      wp_q   <= '0;
    end else begin
      if (cap) begin
        wp_q <= wp_inc;
        if (full) ovf_q <= 1'b1;
        else      cnt_q <= cnt_q + 1'b1;
      end else if (pop) begin
        if (!half_q) begin
          half_q <= 1'b1;
        end else begin
          half_q <= 1'b0;
          cnt_q  <= cnt_q - 1'b1;
          wp_q   <= top_idx;
        end
      end
      if (ctrl_wr) begin
        pwr_q <= reg_wdata[0];
        en_q  <= reg_wdata[1];
        if (reg_wdata[1] && !en_q) half_q <= 1'b0;
        if (!reg_wdata[0]) begin
          cnt_q  <= '0;
          wp_q   <= '0;
          half_q <= 1'b0;
          ovf_q  <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        A_CTRL: reg_rdata[1:0] = {en_q, pwr_q};
        A_STAT: begin
          reg_rdata[CW-1:0] = cnt_q;
          reg_rdata[8]      = ovf_q;
        end
        A_DATA: if (pop) reg_rdata = half_q ? src_m[top_idx] : dst_m[top_idx];
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/jump_trace_buf_chk.sv
module jump_trace_buf_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rec,
  input logic          en,
  input logic          pop,
  input logic          data_rd,
  input logic          half,
  input logic          ovf,
  input logic          pwr_off_wr,
  input logic [CW-1:0] cnt
);
  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  a_r3_no_growth_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rec |=> cnt <= $past(cnt));

  a_r5_target_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !half) |=> (cnt == $past(cnt)) && half);

  a_r5_source_drops_count: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && half) |=> (cnt == $past(cnt) - CW'(1)) && !half);

  a_r6_empty_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !en && cnt == '0) |=> (cnt == '0) && $stable(half));

  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !pwr_off_wr) |=> ovf);

  a_r8_power_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off_wr |=> (cnt == '0) && !ovf);
endmodule

bind jump_trace_buf jump_trace_buf_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rec        (rec),
  .en         (en_q),
  .pop        (pop),
  .data_rd    (data_rd),
  .half       (half_q),
  .ovf        (ovf_q),
  .pwr_off_wr (ctrl_wr && !reg_wdata[0]),
  .cnt        (cnt_q)
);

// File: tb/jump_trace_buf_tb.sv
module jump_trace_buf_tb;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        disc_valid = 1'b0;
  logic [31:0] disc_src = '0, disc_dst = '0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] q_src[$], q_dst[$];
  bit m_pwr = 0, m_en = 0, m_half = 0, m_ovf = 0;

  always #4 clk = ~clk;

  jump_trace_buf u_dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    return (32'(m_ovf) << 8) | 32'(q_src.size());
  endfunction

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    if (a == 2'd0) begin
      if (d[1] && !m_en) m_half = 0;
      m_pwr = d[0]; m_en = d[1];
      if (!d[0]) begin q_src.delete(); q_dst.delete(); m_half = 0; m_ovf = 0; end
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic strobe(logic [31:0] s, logic [31:0] t);
    @(negedge clk); disc_src = s; disc_dst = t; disc_valid = 1'b1;
    @(negedge clk); disc_valid = 1'b0;
    if (m_pwr && m_en) begin
      q_src.push_back(s); q_dst.push_back(t);
      if (q_src.size() > DEPTH) begin
        void'(q_src.pop_front()); void'(q_dst.pop_front()); m_ovf = 1;
      end
    end
  endtask

  task automatic data_chk(string tag);
    logic [31:0] d, e;
    e = 0;
    if (m_pwr && !m_en && q_src.size() != 0) begin
      if (!m_half) begin e = q_dst[$]; m_half = 1; end
      else begin e = q_src[$]; m_half = 0; void'(q_src.pop_back()); void'(q_dst.pop_back()); end
    end
    rd(2'd2, d);
    chk(tag, d, e);
  endtask

  task automatic stat_chk(string tag);
    logic [31:0] d;
    rd(2'd1, d);
    chk(tag, d, exp_status());
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, d); chk("R1 ctrl", d, 0);
    rd(2'd1, d); chk("R1 status", d, 0);
    rd(2'd2, d); chk("R1 data", d, 0);

    // R3: strobe while powered down or with a single bit set
    strobe(32'h10, 32'h20); stat_chk("R3 off");
    wr(2'd0, 32'h2); strobe(32'h11, 32'h21); stat_chk("R3 en_only");
    wr(2'd0, 32'h1); strobe(32'h12, 32'h22); stat_chk("R3 pwr_only");

    // R10 control readback and ignored writes
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, d); chk("R10 ctrl mask", d, 32'h3);
    wr(2'd0, 32'h3);

    // R2 directed three jumps
    strobe(32'h0224, 32'h0250);
    @(negedge clk);
    strobe(32'h025a, 32'h0234);
    strobe(32'h023c, 32'h026c);
    stat_chk("R2 three");
    // R6 read while recording returns 0, no pop
    data_chk("R6 read while rec"); stat_chk("R6 rec no pop");
    wr(2'd0, 32'h1);
    wr(2'd1, 32'h0); wr(2'd2, 32'h0); stat_chk("R10 ignored writes");
    stat_chk("R8 retained");
    for (int i = 0; i < 3; i++) begin
      data_chk("R4 target"); stat_chk("R5 after target");
      data_chk("R4 source"); stat_chk("R5 after source");
    end
    data_chk("R6 empty read"); stat_chk("R6 empty status");

    // R9 half drain then re-enable
    wr(2'd0, 32'h3);
    strobe(32'hA000, 32'hB000); strobe(32'hA100, 32'hB100);
    wr(2'd0, 32'h1);
    data_chk("R9 first target");
    wr(2'd0, 32'h3); wr(2'd0, 32'h1);
    data_chk("R9 restart target"); data_chk("R9 source");
    stat_chk("R9 status");

    // R8 power off clears
    wr(2'd0, 32'h0); stat_chk("R8 power off");
    wr(2'd0, 32'h1); data_chk("R8 empty after off");

    // R7 / R2 random runs with overflow
    for (int r = 0; r < 6; r++) begin
      int n;
      wr(2'd0, 32'h3);
      n = $urandom_range(0, 24);
      for (int k = 0; k < n; k++) begin
        if ($urandom_range(0, 3) == 0) @(negedge clk);
        strobe($urandom, $urandom);
      end
      stat_chk("R7 status after run");
      wr(2'd0, 32'h1);
      strobe($urandom, $urandom);
      stat_chk("R3 stopped");
      while (q_src.size() != 0) begin
        data_chk("R4 rand word");
        if ($urandom_range(0, 1) == 1) stat_chk("R5 rand status");
      end
      data_chk("R6 rand empty");
      stat_chk("R7 sticky after drain");
      wr(2'd0, 32'h0);
      stat_chk("R8 cleared");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule